// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block is one channel of a slave DMA controller. Software sets it up through a small register bus: an address mode for each side, a source address, a destination address and a byte count. It then launches or cancels the transfer by writing a command word that is shared by all channels. After a start, the engine moves one byte per beat. It first fetches a byte on the source port through a valid/ready handshake, then stores that byte on the destination port through a second handshake. After each stored byte, both addresses step by their modes.

The count register counts down as bytes are stored, so software can read back how much is left at any time. The end of a transfer is reported as a one-cycle done pulse. A cancel is reported as an abort pulse. A cancel of a running transfer also raises the done pulse, so software has to look at the abort pulse to tell the two cases apart. A typical memory-to-peripheral setup steps the source up and holds the destination fixed. A peripheral-to-memory setup does the reverse.

Top module: `dmac_chan_top`

## Requirements
- R1: The channel window begins at byte offset 0x100 + 0x40 × CHAN_ID. The window holds the source mode at +0x20, the destination mode at +0x24, the source address at +0x28, the destination address at +0x2C and the byte count at +0x30. Each of these reads back what was last written: mode registers return only bits 5:4, and addresses and count are zero-extended. Every other address reads zero.
- R2: Bits 5:4 of a mode register select how its address moves after each stored byte: 0 steps up by one, 1 steps down by one, and 2 or 3 hold it fixed.
- R3: A write to offset 0x000 is a command to this channel only when bit CHAN_ID of the data is 1. In a command, bit 31 equal to 0 means start and bit 31 equal to 1 means abort. A command that does not select this channel changes nothing.
- R4: Each beat raises src_valid until src_ready is seen, latches src_data, and then raises dst_valid with that byte on dst_data until dst_ready is seen. src_valid and dst_valid are never high together, and dst_data holds steady while dst_valid waits.
- R5: The count reads back the number of bytes not yet stored. It drops by exactly one at each destination handshake.
- R6: On the edge where the last byte is stored, the channel goes idle and evt_done pulses for one cycle in the next cycle, with evt_abort low.
- R7: An abort that arrives while a transfer runs stops it at the next edge. Both evt_abort and evt_done pulse in the next cycle, and both valids drop. An abort that arrives while the channel is idle pulses evt_abort only.
- R8: A start with a count of zero pulses evt_done in the next cycle and issues no beat.
- R9: While a transfer runs, writes to the mode, address and count registers are ignored, and a second start is ignored.
- R10: If an abort arrives in the same cycle as a destination handshake, that byte counts: the count drops and the addresses step. The transfer then ends with both evt_abort and evt_done.
- R11: After reset the channel is idle, every register reads zero and no pulse or valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address (controller-relative) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| src_valid | output | 1 | Fetch request on the source port |
| src_ready | input | 1 | Source accepts the fetch and presents src_data |
| src_addr | output | AW | Current source address |
| src_data | input | 8 | Fetched byte |
| dst_valid | output | 1 | Store request on the destination port |
| dst_ready | input | 1 | Destination accepts the store |
| dst_addr | output | AW | Current destination address |
| dst_data | output | 8 | Byte being stored |
| evt_done | output | 1 | One-cycle transfer-ended pulse |
| evt_abort | output | 1 | One-cycle abort pulse |

## Verification
The sharpest collision is an abort command landing on the same edge as a destination handshake. The bench provokes it by holding dst_ready low until dst_valid shows, then releasing it in the same cycle as it writes the abort word. It then judges whether the byte counted: the remaining count must be one lower, and both pulses must appear. A second collision arises when a configuration write or a second start hits the bus while a beat is completing. The behavioural reference model, compared every clock, expects the write to be dropped while the address still steps.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        AM_INC = 2'd0,
        AM_DEC = 2'd1,
        AM_FIX = 2'd2,
        AM_HLD = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } beat_st_e;

    localparam logic [11:0] CMD_OFS     = 12'h000;
    localparam logic [11:0] WIN_FIRST   = 12'h100;
    localparam logic [11:0] WIN_STRIDE  = 12'h040;
    localparam logic [5:0]  OFS_SMODE   = 6'h20;
    localparam logic [5:0]  OFS_DMODE   = 6'h24;
    localparam logic [5:0]  OFS_SADDR   = 6'h28;
    localparam logic [5:0]  OFS_DADDR   = 6'h2C;
    localparam logic [5:0]  OFS_COUNT   = 6'h30;
    localparam int          ABORT_BIT   = 31;
    localparam int          MODE_LSB    = 4;

endpackage

// File: rtl/dmac_reg_decode.sv
module dmac_reg_decode
    import dmac_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        busy,
    output logic        wr_smode,
    output logic        wr_dmode,
    output logic        wr_saddr,
    output logic        wr_daddr,
    output logic        wr_count,
    output logic        cmd_start,
    output logic        cmd_abort
);
    localparam logic [11:0] WIN_BASE = WIN_FIRST + 12'(CHAN_ID) * WIN_STRIDE;

    logic in_win;
    logic cfg_ok;
    logic cmd_hit;

    always_comb begin
        in_win    = (bus_addr[11:6] == WIN_BASE[11:6]);
        cfg_ok    = bus_wr && in_win && !busy;
        cmd_hit   = bus_wr && (bus_addr == CMD_OFS) && bus_wdata[CHAN_ID];
        wr_smode  = cfg_ok && (bus_addr[5:0] == OFS_SMODE);
        wr_dmode  = cfg_ok && (bus_addr[5:0] == OFS_DMODE);
        wr_saddr  = cfg_ok && (bus_addr[5:0] == OFS_SADDR);
        wr_daddr  = cfg_ok && (bus_addr[5:0] == OFS_DADDR);
        wr_count  = cfg_ok && (bus_addr[5:0] == OFS_COUNT);
        cmd_start = cmd_hit && !bus_wdata[ABORT_BIT];
        cmd_abort = cmd_hit &&  bus_wdata[ABORT_BIT];
    end

endmodule

// File: rtl/dmac_addr_gen.sv
module dmac_addr_gen
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [1:0]    mode_in,
    input  logic          addr_wr,
    input  logic [AW-1:0] addr_in,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [1:0]    mode
);
    typedef struct packed {
        logic [1:0]    mode;
        logic [AW-1:0] addr;
    } ag_state_t;

    ag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mode_wr) s_d.mode = mode_in;
        if (addr_wr) begin
            s_d.addr = addr_in;
        end else if (step) begin
            unique case (addr_mode_e'(s_q.mode))
                AM_INC:  s_d.addr = s_q.addr + AW'(1);
                AM_DEC:  s_d.addr = s_q.addr - AW'(1);
                default: s_d.addr = s_q.addr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;
    assign mode = s_q.mode;

    p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_wr && mode == 2'd0) |=> addr == $past(addr) + AW'(1))
        else $error("R2 increment step wrong");

    p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_wr && mode == 2'd1) |=> addr == $past(addr) - AW'(1))
        else $error("R2 decrement step wrong");

    p_step_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_wr && mode[1]) |=> $stable(addr))
        else $error("R2 fixed address moved");

endmodule

// File: rtl/dmac_beat_fsm.sv
module dmac_beat_fsm
    import dmac_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_in,
    input  logic          start,
    input  logic          abort,
    input  logic          src_ready,
    input  logic [DW-1:0] src_data,
    input  logic          dst_ready,
    output logic          src_valid,
    output logic          dst_valid,
    output logic [DW-1:0] dst_data,
    output logic [CW-1:0] count,
    output logic          busy,
    output logic          beat_done,
    output logic          evt_done,
    output logic          evt_abort
);
    typedef struct packed {
        beat_st_e      st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          done;
        logic          abrt;
    } fsm_state_t;

    fsm_state_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        f_d.abrt = 1'b0;
        unique case (f_q.st)
            ST_FETCH: begin
                if (src_ready) begin
                    f_d.data = src_data;
                    f_d.st   = ST_STORE;
                end
            end
            ST_STORE: begin
                if (dst_ready) begin
                    f_d.cnt = f_q.cnt - CW'(1);
                    if (f_q.cnt == CW'(1)) begin
                        f_d.st   = ST_IDLE;
                        f_d.done = 1'b1;
                    end else begin
                        f_d.st = ST_FETCH;
                    end
                end
            end
            default: begin
                if (cnt_wr) f_d.cnt = cnt_in;
                if (start && !abort) begin
                    if (f_q.cnt == '0) f_d.done = 1'b1;
                    else               f_d.st   = ST_FETCH;
                end
            end
        endcase
        if (abort) begin
            f_d.abrt = 1'b1;
            if (f_q.st != ST_IDLE) begin
                f_d.st   = ST_IDLE;
                f_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, cnt: '0, data: '0, done: 1'b0, abrt: 1'b0};
        else        f_q <= f_d;
    end

    assign src_valid = (f_q.st == ST_FETCH);
    assign dst_valid = (f_q.st == ST_STORE);
    assign dst_data  = f_q.data;
    assign count     = f_q.cnt;
    assign busy      = (f_q.st != ST_IDLE);
    assign beat_done = dst_valid && dst_ready;
    assign evt_done  = f_q.done;
    assign evt_abort = f_q.abrt;

    p_valid_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_valid && dst_valid))
        else $error("R4 both valids high");

    p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready && !abort) |=> (dst_valid && $stable(dst_data)))
        else $error("R4 store not held");

    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> count == $past(count) - CW'(1))
        else $error("R5 count did not drop by one");

    p_abort_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> (evt_abort && evt_done && !src_valid && !dst_valid))
        else $error("R7 abort of running transfer wrong");

    p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && !busy && count == '0) |=> (evt_done && !evt_abort && !src_valid))
        else $error("R8 zero-count start wrong");

endmodule

// File: rtl/dmac_chan_top.sv
module dmac_chan_top
    import dmac_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int AW      = 32,
    parameter int CW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          src_valid,
    input  logic          src_ready,
    output logic [AW-1:0] src_addr,
    input  logic [7:0]    src_data,
    output logic          dst_valid,
    input  logic          dst_ready,
    output logic [AW-1:0] dst_addr,
    output logic [7:0]    dst_data,
    output logic          evt_done,
    output logic          evt_abort
);
    localparam logic [11:0] WIN_BASE = WIN_FIRST + 12'(CHAN_ID) * WIN_STRIDE;
    localparam int          NSIDE    = 2;

    logic          wr_smode, wr_dmode, wr_saddr, wr_daddr, wr_count;
    logic          cmd_start, cmd_abort;
    logic          busy, beat_done;
    logic [CW-1:0] count;
    logic [1:0]    smode, dmode;

    logic [NSIDE-1:0]         side_mode_wr;
    logic [NSIDE-1:0]         side_addr_wr;
    logic [NSIDE-1:0][AW-1:0] side_addr;
    logic [NSIDE-1:0][1:0]    side_mode;

    dmac_reg_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .wr_smode  (wr_smode),
        .wr_dmode  (wr_dmode),
        .wr_saddr  (wr_saddr),
        .wr_daddr  (wr_daddr),
        .wr_count  (wr_count),
        .cmd_start (cmd_start),
        .cmd_abort (cmd_abort)
    );

    assign side_mode_wr = {wr_dmode, wr_smode};
    assign side_addr_wr = {wr_daddr, wr_saddr};

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dmac_addr_gen #(.AW(AW)) u_ag (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_wr (side_mode_wr[g]),
            .mode_in (bus_wdata[MODE_LSB+1:MODE_LSB]),
            .addr_wr (side_addr_wr[g]),
            .addr_in (bus_wdata[AW-1:0]),
            .step    (beat_done),
            .addr    (side_addr[g]),
            .mode    (side_mode[g])
        );
    end

    assign src_addr = side_addr[0];
    assign dst_addr = side_addr[1];
    assign smode    = side_mode[0];
    assign dmode    = side_mode[1];

    dmac_beat_fsm #(.CW(CW), .DW(8)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (wr_count),
        .cnt_in    (bus_wdata[CW-1:0]),
        .start     (cmd_start),
        .abort     (cmd_abort),
        .src_ready (src_ready),
        .src_data  (src_data),
        .dst_ready (dst_ready),
        .src_valid (src_valid),
        .dst_valid (dst_valid),
        .dst_data  (dst_data),
        .count     (count),
        .busy      (busy),
        .beat_done (beat_done),
        .evt_done  (evt_done),
        .evt_abort (evt_abort)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:6] == WIN_BASE[11:6]) begin
            unique case (bus_addr[5:0])
                OFS_SMODE: bus_rdata = 32'(smode) << MODE_LSB;
                OFS_DMODE: bus_rdata = 32'(dmode) << MODE_LSB;
                OFS_SADDR: bus_rdata = 32'(src_addr);
                OFS_DADDR: bus_rdata = 32'(dst_addr);
                OFS_COUNT: bus_rdata = 32'(count);
                default:   bus_rdata = '0;
            endcase
        end
    end

    logic saddr_hit_raw;
    assign saddr_hit_raw = bus_wr && (bus_addr == WIN_BASE + 12'(OFS_SADDR));

    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && saddr_hit_raw && !beat_done) |=> $stable(src_addr))
        else $error("R9 write while busy took effect");

    p_cnt_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_done && !cmd_abort) |=> $stable(count))
        else $error("R9 count changed without a beat");

endmodule

// File: tb/sim_dmac_chan_top.sv
module sim_dmac_chan_top;
    localparam int CLK_PERIOD = 10;
    localparam int CH         = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        src_valid, src_ready, dst_valid, dst_ready;
    logic [31:0] src_addr, dst_addr;
    logic [7:0]  src_data, dst_data;
    logic        evt_done, evt_abort;

    logic        fast = 1'b1;
    logic        src_hold = 1'b0;
    logic        dst_hold = 1'b0;
    logic [7:0]  pat = 8'hA5;

    int vectors = 0;
    int miscompares = 0;
    int n_src = 0, n_dst = 0, n_done = 0, n_abort = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_ready = !src_hold && (fast || pat[0]);
    assign dst_ready = !dst_hold && (fast || pat[3]);
    assign src_data  = src_addr[7:0] ^ 8'h5A;

    dmac_chan_top #(.CHAN_ID(CH), .AW(32), .CW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr), .src_data(src_data),
        .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_addr(dst_addr), .dst_data(dst_data),
        .evt_done(evt_done), .evt_abort(evt_abort)
    );

    always @(negedge clk) pat <= {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};

    // behavioural reference model
    int          m_st = 0;
    logic [31:0] m_sa = 0, m_da = 0;
    logic [15:0] m_cnt = 0;
    logic [1:0]  m_sm = 0, m_dm = 0;
    logic [7:0]  m_byte = 0;
    bit          m_ed = 0, m_ea = 0;

    function automatic logic [31:0] stepf(logic [31:0] a, logic [1:0] m);
        if (m == 2'd0) return a + 1;
        if (m == 2'd1) return a - 1;
        return a;
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        case (a)
            12'h120: return {26'b0, m_sm, 4'b0};
            12'h124: return {26'b0, m_dm, 4'b0};
            12'h128: return m_sa;
            12'h12C: return m_da;
            12'h130: return {16'b0, m_cnt};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sa = 0; m_da = 0; m_cnt = 0; m_sm = 0; m_dm = 0;
            m_byte = 0; m_ed = 0; m_ea = 0;
        end else begin
            int  was;
            bit  cmd;
            was  = m_st;
            cmd  = bus_wr && bus_addr == 12'h000 && bus_wdata[CH];
            m_ed = 0; m_ea = 0;
            if (was == 1 && src_ready) begin
                m_byte = m_sa[7:0] ^ 8'h5A; m_st = 2;
            end else if (was == 2 && dst_ready) begin
                m_cnt = m_cnt - 1;
                m_sa  = stepf(m_sa, m_sm);
                m_da  = stepf(m_da, m_dm);
                if (m_cnt == 0) begin m_st = 0; m_ed = 1; end
                else m_st = 1;
            end
            if (cmd && bus_wdata[31]) begin
                m_ea = 1;
                if (was != 0) begin m_st = 0; m_ed = 1; end
            end else if (cmd && was == 0) begin
                if (m_cnt == 0) m_ed = 1; else m_st = 1;
            end
            if (bus_wr && was == 0) begin
                case (bus_addr)
                    12'h120: m_sm  = bus_wdata[5:4];
                    12'h124: m_dm  = bus_wdata[5:4];
                    12'h128: m_sa  = bus_wdata;
                    12'h12C: m_da  = bus_wdata;
                    12'h130: m_cnt = bus_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(src_valid == (m_st == 1), "R4 src_valid", 32'(src_valid), 32'(m_st == 1));
            chk(dst_valid == (m_st == 2), "R4 dst_valid", 32'(dst_valid), 32'(m_st == 2));
            if (dst_valid) chk(dst_data == m_byte, "R4 dst_data", 32'(dst_data), 32'(m_byte));
            chk(src_addr == m_sa, "R2 src_addr", src_addr, m_sa);
            chk(dst_addr == m_da, "R2 dst_addr", dst_addr, m_da);
            chk(evt_done == m_ed, "R6 evt_done", 32'(evt_done), 32'(m_ed));
            chk(evt_abort == m_ea, "R7 evt_abort", 32'(evt_abort), 32'(m_ea));
            chk(bus_rdata == exp_rd(bus_addr), "R1 bus_rdata", bus_rdata, exp_rd(bus_addr));
            if (src_valid && src_ready) n_src++;
            if (dst_valid && dst_ready) n_dst++;
            if (evt_done)  n_done++;
            if (evt_abort) n_abort++;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic setup(input logic [1:0] sm, input logic [1:0] dm,
                         input logic [31:0] sa, input logic [31:0] da, input logic [15:0] n);
        wr(12'h120, {26'b0, sm, 4'b0});
        wr(12'h124, {26'b0, dm, 4'b0});
        wr(12'h128, sa);
        wr(12'h12C, da);
        wr(12'h130, {16'b0, n});
    endtask

    task automatic wait_done();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #2;
            if (evt_done) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int d0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd_chk(12'h130, 32'h0, "R11 count after reset");
        rd_chk(12'h128, 32'h0, "R11 src addr after reset");
        chk(!src_valid && !dst_valid && !evt_done, "R11 idle outputs", 32'(src_valid), 32'h0);

        // R1 readback of configuration, memory to peripheral
        setup(2'd0, 2'd2, 32'h0000_1000, 32'h0000_2000, 16'd5);
        rd_chk(12'h124, 32'h0000_0020, "R1 dst mode readback");
        rd_chk(12'h12C, 32'h0000_2000, "R1 dst addr readback");
        rd_chk(12'h0F0, 32'h0, "R1 unmapped reads zero");
        bus_addr = 12'h130;
        wr(12'h000, 32'h0000_0001);
        wait_done();
        chk(evt_done && !evt_abort, "R6 normal end pulses", {30'b0, evt_abort, evt_done}, 32'h1);
        rd_chk(12'h130, 32'h0, "R5 count drained");
        rd_chk(12'h128, 32'h0000_1005, "R2 incremented src");
        rd_chk(12'h12C, 32'h0000_2000, "R2 fixed dst");

        // peripheral to memory with random-ish handshakes
        fast = 1'b0;
        setup(2'd2, 2'd0, 32'h0000_4000, 32'h0000_5000, 16'd4);
        wr(12'h000, 32'h0000_0001);
        wait_done();
        rd_chk(12'h12C, 32'h0000_5004, "R2 incremented dst");

        // R2 decrement both, mode 3 held
        setup(2'd1, 2'd1, 32'h0000_0010, 32'h0000_0100, 16'd3);
        wr(12'h000, 32'h0000_0001);
        wait_done();
        rd_chk(12'h128, 32'h0000_000D, "R2 decremented src");
        setup(2'd3, 2'd0, 32'h0000_0077, 32'h0, 16'd2);
        wr(12'h000, 32'h0000_0001);
        wait_done();
        rd_chk(12'h128, 32'h0000_0077, "R2 mode 3 holds");

        // R8 zero count
        fast = 1'b1;
        wr(12'h130, 32'h0);
        s0 = n_src; d0 = n_done;
        wr(12'h000, 32'h0000_0001);
        repeat (3) @(negedge clk);
        chk(n_src == s0, "R8 no beat", 32'(n_src - s0), 32'h0);
        chk(n_done == d0 + 1, "R8 one done", 32'(n_done - d0), 32'h1);

        // R3 command for another channel
        wr(12'h130, 32'h2);
        s0 = n_src; d0 = n_abort;
        wr(12'h000, 32'h0000_0002);
        wr(12'h000, 32'h8000_0002);
        repeat (3) @(negedge clk);
        chk(n_src == s0 && n_abort == d0, "R3 foreign command ignored", 32'(n_src - s0), 32'h0);
        rd_chk(12'h130, 32'h2, "R3 count unchanged");

        // R9 writes and restart while busy
        fast = 1'b0;
        setup(2'd0, 2'd2, 32'h0000_3000, 32'h0000_0040, 16'd8);
        wr(12'h000, 32'h0000_0001);
        wr(12'h128, 32'h0000_DEAD);
        wr(12'h130, 32'h0000_0055);
        wr(12'h120, 32'h0000_0010);
        wr(12'h000, 32'h0000_0001);
        wait_done();
        rd_chk(12'h128, 32'h0000_3008, "R9 src addr write ignored");
        rd_chk(12'h120, 32'h0, "R9 mode write ignored");

        // R7 abort while running, then abort while idle
        setup(2'd0, 2'd0, 32'h0000_6000, 32'h0000_7000, 16'd6);
        wr(12'h000, 32'h0000_0001);
        repeat (4) @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h8000_0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
        #2;
        chk(evt_abort && evt_done && !src_valid && !dst_valid, "R7 busy abort",
            {29'b0, dst_valid, evt_done, evt_abort}, 32'h3);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h8000_0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
        #2;
        chk(evt_abort && !evt_done, "R7 idle abort", {30'b0, evt_done, evt_abort}, 32'h1);

        // R10 abort on the same edge as a store handshake
        fast = 1'b1;
        setup(2'd0, 2'd2, 32'h0000_8000, 32'h0000_9000, 16'd3);
        dst_hold = 1'b1;
        wr(12'h000, 32'h0000_0001);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #2;
            if (dst_valid) break;
        end
        @(negedge clk);
        dst_hold = 1'b0;
        bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h8000_0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0; bus_addr = 12'h130;
        #2;
        chk(bus_rdata == 32'h2, "R10 colliding beat counted", bus_rdata, 32'h2);
        chk(evt_abort && evt_done, "R10 both pulses", {30'b0, evt_done, evt_abort}, 32'h3);
        rd_chk(12'h128, 32'h0000_8001, "R10 address stepped");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule